// File: doc/BRIEF.md
# AC97 Link Controller Command Interface

This block is the software-facing front end of an AC97 link controller. A processor reaches it through a small word-addressed register port. Through that port it sets the link configuration, powers the controller up, reads status, and sends codec register reads and writes. A single command/response register takes each command. A busy flag stays up while the command travels over the link. For a read, the codec's answer comes back in the low half of the same register.

On the link side, the serial framing is reduced to a frame-tick interface. Each pulse on `frame_tick` marks one link frame. The block issues a pending command as a one-cycle slot pulse on the first enabled frame. It takes the codec's returned status slot, which carries the ready tag and read data, on a valid strobe. The block also drives the codec cold-reset line, the warm-reset sync force, the sync gate and the two 10-bit slot-valid masks. It keeps sticky FIFO error flags and shows the live FIFO level flags.

A read answer can be seen only for a short window of frames. If no status slot arrives in time, a read gives up and the response field returns all ones.

Top module: `ac97_cmd_ctrl`

## Requirements
- R1: After reset the configuration register (offset 0x00) reads 0, the enable register (offset 0x10) reads 0x2, the status register (offset 0x04) reads 0 when all FIFO flag inputs are low, the command/response register (offset 0x0C) reads 0x0000FFFF, and `acrst_n` is high.
- R2: A write to offset 0x0C while no command is pending accepts the command: bits 6:0 are the codec register index, bit 7 set means read, and bits 31:16 are the write data. Status bit 6 (pending) reads 1 from the next cycle on.
- R3: A pending command is issued on the first enabled frame tick. `lnk_cmd_valid` is high for exactly one cycle, in the cycle after that tick, with `lnk_cmd_idx`, `lnk_cmd_rd` and `lnk_cmd_wdata` equal to the accepted fields. No pulse appears before a frame tick.
- R4: For a write command, pending stays set until the next enabled frame tick after the issue, and clears at that tick.
- R5: For a read command, pending clears when a status slot (`lnk_sts_valid`) arrives after the issue. Its `lnk_sts_data` then reads in bits 15:0 of offset 0x0C.
- R6: Read data stays visible for RESP_FRAMES (default 2) enabled frame ticks after it is captured. From then on, bits 15:0 of offset 0x0C read 0xFFFF.
- R7: If no status slot arrives within READ_TMO_FRAMES (default 4) enabled frame ticks after a read is issued, pending clears on the last of those ticks and bits 15:0 of offset 0x0C read 0xFFFF.
- R8: A write to offset 0x0C while pending is set is ignored, so the command already in flight goes out unchanged. It sets status bit 12, which stays set until a write to offset 0x04 with bit 12 set.
- R9: Status bits 11, 10, 9 and 8 latch pulses on `fifo_err_ev[3]` (tx underflow), `[2]` (tx overflow), `[1]` (rx underflow) and `[0]` (rx overflow). Each stays set until a write of 1 to its own bit at offset 0x04. Bits 4, 3, 1 and 0 show the live tx-empty, tx-full, rx-empty and rx-full inputs.
- R10: Configuration bit 0 drives `acrst_n` low (cold reset), bit 1 drives `sync_force`, bit 2 drives `sync_gate`, bits 12:3 drive `tx_slot_en` and bits 22:13 drive `rx_slot_en`. The register reads back as written.
- R11: Status bit 7 (codec ready) takes the `lnk_sts_ready` tag of each arriving status slot. While configuration bit 0 is set it is cleared and held at 0.
- R12: Enable bit 0 drives `clk_en` and bit 1 drives `blk_off`. Frame ticks have no effect unless bit 0 is 1 and bit 1 is 0. While that does not hold, no command is issued and pending does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| frame_tick | input | 1 | One-cycle pulse per link frame |
| lnk_cmd_valid | output | 1 | Command slot issued this frame |
| lnk_cmd_rd | output | 1 | Issued command is a read |
| lnk_cmd_idx | output | 7 | Codec register index |
| lnk_cmd_wdata | output | 16 | Codec write data |
| lnk_sts_valid | input | 1 | Status slot received |
| lnk_sts_ready | input | 1 | Codec ready tag of the status slot |
| lnk_sts_data | input | 16 | Read data of the status slot |
| fifo_tx_empty | input | 1 | Live tx FIFO empty flag |
| fifo_tx_full | input | 1 | Live tx FIFO full flag |
| fifo_rx_empty | input | 1 | Live rx FIFO empty flag |
| fifo_rx_full | input | 1 | Live rx FIFO full flag |
| fifo_err_ev | input | 4 | FIFO error event pulses (tx under, tx over, rx under, rx over) |
| acrst_n | output | 1 | Codec cold reset, active low |
| sync_force | output | 1 | Forced sync for warm reset |
| sync_gate | output | 1 | Sync gating |
| tx_slot_en | output | 10 | Transmit slot-valid mask |
| rx_slot_en | output | 10 | Receive slot-valid mask |
| clk_en | output | 1 | Controller clock enable |
| blk_off | output | 1 | Controller disable |

## Verification
A command engine stuck in the wrong state shows up at once in status bit 6. It shows on the link one frame later: the slot pulse goes missing, comes twice, or carries fields from a rejected write. A fault in the response window or the timeout counter shows in the low half of the command/response register. Within RESP_FRAMES or READ_TMO_FRAMES ticks, that field turns to 0xFFFF too early or too late. A wrong sticky bit or ready flag is visible in the very next status read, before and after the write-one clear.

// File: rtl/ac97_cmd_pkg.sv
package ac97_cmd_pkg;

  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_CFG = 5'h00;
  localparam logic [REG_AW-1:0] OFS_STS = 5'h04;
  localparam logic [REG_AW-1:0] OFS_DAT = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CMD = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_ENA = 5'h10;

  // status bit positions
  localparam int ST_ERR  = 12;
  localparam int ST_FEV  = 8;   // 4 sticky bits 11:8
  localparam int ST_RDY  = 7;
  localparam int ST_PEND = 6;
  localparam int ST_TXE  = 4;
  localparam int ST_TXF  = 3;
  localparam int ST_RXE  = 1;
  localparam int ST_RXF  = 0;

  // command word fields
  localparam int CMD_RD_BIT = 7;
  localparam int CMD_DAT_LO = 16;

  localparam logic [1:0] ENA_RESET = 2'b10;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_WAIT,
    ENG_SENT_WR,
    ENG_SENT_RD
  } eng_state_t;

endpackage

// File: rtl/ac97_ctl_regs.sv
module ac97_ctl_regs
  import ac97_cmd_pkg::*;
#(
  parameter int SLOT_W = 10,
  parameter int NUM_FEV = 4,
  localparam int CFG_W = 3 + 2 * SLOT_W
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               wr_cfg,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               wr_ena,
  input  logic [1:0]         ena_wdata,
  input  logic               wr_sts,
  input  logic               clr_err,
  input  logic [NUM_FEV-1:0] clr_fev,
  input  logic               cmd_reject,
  input  logic [NUM_FEV-1:0] fev_in,
  input  logic               sts_valid,
  input  logic               sts_ready,
  output logic [CFG_W-1:0]   cfg_q,
  output logic [1:0]         ena_q,
  output logic [NUM_FEV-1:0] fev_q,
  output logic               err_q,
  output logic               rdy_q
);

  logic [CFG_W-1:0]   cfg_d;
  logic [1:0]         ena_d;
  logic [NUM_FEV-1:0] fev_d;
  logic               err_d;
  logic               rdy_d;

  always_comb begin
    cfg_d = cfg_q;
    ena_d = ena_q;
    if (wr_cfg) cfg_d = cfg_wdata;
    if (wr_ena) ena_d = ena_wdata;
    err_d = cmd_reject | (err_q & ~(wr_sts & clr_err));
    if (cfg_q[0])       rdy_d = 1'b0;
    else if (sts_valid) rdy_d = sts_ready;
    else                rdy_d = rdy_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ena_q <= ENA_RESET;
      err_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_d;
      if (wr_ena) ena_q <= ena_d;
      err_q <= err_d;
      rdy_q <= rdy_d;
    end
  end

  for (genvar i = 0; i < NUM_FEV; i++) begin : g_fev
    assign fev_d[i] = fev_in[i] | (fev_q[i] & ~(wr_sts & clr_fev[i]));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) fev_q[i] <= 1'b0;
      else         fev_q[i] <= fev_d[i];
    end

    AST_FEV_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
      (fev_q[i] && !(wr_sts && clr_fev[i])) |=> fev_q[i]); // R9
  end

  AST_RDY_COLD: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_q[0] |=> !rdy_q); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_q && !(wr_sts && clr_err)) |=> err_q); // R8

endmodule

// File: rtl/ac97_cmd_engine.sv
module ac97_cmd_engine
  import ac97_cmd_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int CDATA_W = 16,
  parameter int RESP_FRAMES = 2,
  parameter int READ_TMO_FRAMES = 4,
  localparam int WIN_W = $clog2(RESP_FRAMES + 1),
  localparam int TMO_W = $clog2(READ_TMO_FRAMES + 1)
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               cmd_wr,
  input  logic [IDX_W-1:0]   cmd_idx,
  input  logic               cmd_rd,
  input  logic [CDATA_W-1:0] cmd_wdata,
  input  logic               tick,
  input  logic               sts_valid,
  input  logic [CDATA_W-1:0] sts_data,
  output logic               pending,
  output logic               reject,
  output logic               lnk_valid,
  output logic               lnk_rd,
  output logic [IDX_W-1:0]   lnk_idx,
  output logic [CDATA_W-1:0] lnk_wdata,
  output logic [CDATA_W-1:0] resp_rd
);

  eng_state_t         st_q, st_d;
  logic               vld_d;
  logic               load_cmd;
  logic [TMO_W-1:0]   tmo_q, tmo_d;
  logic [WIN_W-1:0]   win_q, win_d;
  logic [CDATA_W-1:0] resp_q, resp_d;

  always_comb begin
    st_d     = st_q;
    vld_d    = 1'b0;
    load_cmd = 1'b0;
    tmo_d    = tmo_q;
    win_d    = win_q;
    resp_d   = resp_q;
    reject   = cmd_wr && (st_q != ENG_IDLE);
    if (tick && win_q != '0) win_d = win_q - 1'b1;
    unique case (st_q)
      ENG_IDLE: begin
        if (cmd_wr) begin
          load_cmd = 1'b1;
          st_d     = ENG_WAIT;
        end
      end
      ENG_WAIT: begin
        if (tick) begin
          vld_d = 1'b1;
          tmo_d = '0;
          st_d  = lnk_rd ? ENG_SENT_RD : ENG_SENT_WR;
        end
      end
      ENG_SENT_WR: begin
        if (tick) st_d = ENG_IDLE;
      end
      ENG_SENT_RD: begin
        if (sts_valid) begin
          resp_d = sts_data;
          win_d  = WIN_W'(RESP_FRAMES);
          st_d   = ENG_IDLE;
        end else if (tick) begin
          if (tmo_q == TMO_W'(READ_TMO_FRAMES - 1)) begin
            win_d = '0;
            st_d  = ENG_IDLE;
          end else begin
            tmo_d = tmo_q + 1'b1;
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ENG_IDLE;
      lnk_valid <= 1'b0;
      tmo_q     <= '0;
      win_q     <= '0;
      resp_q    <= '0;
      lnk_rd    <= 1'b0;
      lnk_idx   <= '0;
      lnk_wdata <= '0;
    end else begin
      st_q      <= st_d;
      lnk_valid <= vld_d;
      tmo_q     <= tmo_d;
      win_q     <= win_d;
      resp_q    <= resp_d;
      if (load_cmd) begin
        lnk_rd    <= cmd_rd;
        lnk_idx   <= cmd_idx;
        lnk_wdata <= cmd_wdata;
      end
    end
  end

  assign pending = (st_q != ENG_IDLE);
  assign resp_rd = (win_q != '0) ? resp_q : '1;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    lnk_valid |=> !lnk_valid); // R3

  AST_ISSUE_PENDING: assert property (@(posedge clk) disable iff (!rst_ni)
    lnk_valid |-> pending); // R3

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_wr && pending) |=> ($stable(lnk_idx) && $stable(lnk_wdata) && $stable(lnk_rd))); // R8

  AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick && !sts_valid && !cmd_wr) |=> $stable(pending)); // R4

endmodule

// File: rtl/ac97_cmd_ctrl.sv
module ac97_cmd_ctrl
  import ac97_cmd_pkg::*;
#(
  parameter int SLOT_W = 10,
  parameter int IDX_W = 7,
  parameter int CDATA_W = 16,
  parameter int RESP_FRAMES = 2,
  parameter int READ_TMO_FRAMES = 4,
  localparam int CFG_W = 3 + 2 * SLOT_W,
  localparam int NUM_FEV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               frame_tick,
  output logic               lnk_cmd_valid,
  output logic               lnk_cmd_rd,
  output logic [IDX_W-1:0]   lnk_cmd_idx,
  output logic [CDATA_W-1:0] lnk_cmd_wdata,
  input  logic               lnk_sts_valid,
  input  logic               lnk_sts_ready,
  input  logic [CDATA_W-1:0] lnk_sts_data,
  input  logic               fifo_tx_empty,
  input  logic               fifo_tx_full,
  input  logic               fifo_rx_empty,
  input  logic               fifo_rx_full,
  input  logic [NUM_FEV-1:0] fifo_err_ev,
  output logic               acrst_n,
  output logic               sync_force,
  output logic               sync_gate,
  output logic [SLOT_W-1:0]  tx_slot_en,
  output logic [SLOT_W-1:0]  rx_slot_en,
  output logic               clk_en,
  output logic               blk_off
);

  logic [1:0]         rst_sync_q;
  logic               rst_ni;
  logic               wr_cfg, wr_sts, wr_cmd, wr_ena;
  logic [CFG_W-1:0]   cfg_q;
  logic [1:0]         ena_q;
  logic [NUM_FEV-1:0] fev_q;
  logic               err_q, rdy_q;
  logic               link_on, tick_en;
  logic               pending, reject;
  logic [CDATA_W-1:0] resp_rd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign wr_cfg = reg_wr && (reg_addr == OFS_CFG);
  assign wr_sts = reg_wr && (reg_addr == OFS_STS);
  assign wr_cmd = reg_wr && (reg_addr == OFS_CMD);
  assign wr_ena = reg_wr && (reg_addr == OFS_ENA);

  assign link_on = ena_q[0] & ~ena_q[1];
  assign tick_en = frame_tick & link_on;

  ac97_ctl_regs #(
    .SLOT_W (SLOT_W),
    .NUM_FEV(NUM_FEV)
  ) u_regs (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_cfg    (wr_cfg),
    .cfg_wdata (reg_wdata[CFG_W-1:0]),
    .wr_ena    (wr_ena),
    .ena_wdata (reg_wdata[1:0]),
    .wr_sts    (wr_sts),
    .clr_err   (reg_wdata[ST_ERR]),
    .clr_fev   (reg_wdata[ST_FEV +: NUM_FEV]),
    .cmd_reject(reject),
    .fev_in    (fifo_err_ev),
    .sts_valid (lnk_sts_valid),
    .sts_ready (lnk_sts_ready),
    .cfg_q     (cfg_q),
    .ena_q     (ena_q),
    .fev_q     (fev_q),
    .err_q     (err_q),
    .rdy_q     (rdy_q)
  );

  ac97_cmd_engine #(
    .IDX_W          (IDX_W),
    .CDATA_W        (CDATA_W),
    .RESP_FRAMES    (RESP_FRAMES),
    .READ_TMO_FRAMES(READ_TMO_FRAMES)
  ) u_eng (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .cmd_wr   (wr_cmd),
    .cmd_idx  (reg_wdata[IDX_W-1:0]),
    .cmd_rd   (reg_wdata[CMD_RD_BIT]),
    .cmd_wdata(reg_wdata[CMD_DAT_LO +: CDATA_W]),
    .tick     (tick_en),
    .sts_valid(lnk_sts_valid),
    .sts_data (lnk_sts_data),
    .pending  (pending),
    .reject   (reject),
    .lnk_valid(lnk_cmd_valid),
    .lnk_rd   (lnk_cmd_rd),
    .lnk_idx  (lnk_cmd_idx),
    .lnk_wdata(lnk_cmd_wdata),
    .resp_rd  (resp_rd)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CFG: reg_rdata[CFG_W-1:0] = cfg_q;
      OFS_STS: begin
        reg_rdata[ST_ERR]              = err_q;
        reg_rdata[ST_FEV +: NUM_FEV]   = fev_q;
        reg_rdata[ST_RDY]              = rdy_q;
        reg_rdata[ST_PEND]             = pending;
        reg_rdata[ST_TXE]              = fifo_tx_empty;
        reg_rdata[ST_TXF]              = fifo_tx_full;
        reg_rdata[ST_RXE]              = fifo_rx_empty;
        reg_rdata[ST_RXF]              = fifo_rx_full;
      end
      OFS_DAT: reg_rdata = '0;
      OFS_CMD: reg_rdata[CDATA_W-1:0] = resp_rd;
      OFS_ENA: reg_rdata[1:0] = ena_q;
      default: reg_rdata = '0;
    endcase
  end

  assign acrst_n    = ~cfg_q[0];
  assign sync_force = cfg_q[1];
  assign sync_gate  = cfg_q[2];
  assign tx_slot_en = cfg_q[3 +: SLOT_W];
  assign rx_slot_en = cfg_q[3 + SLOT_W +: SLOT_W];
  assign clk_en     = ena_q[0];
  assign blk_off    = ena_q[1];

  AST_LINK_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clk_en || blk_off) |=> !lnk_cmd_valid); // R12

endmodule

// File: tb/sim_ac97_cmd_ctrl.sv
module sim_ac97_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CFG = 5'h00, A_STS = 5'h04, A_CMD = 5'h0C, A_ENA = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_tick = 1'b0;
  logic        lnk_cmd_valid, lnk_cmd_rd;
  logic [6:0]  lnk_cmd_idx;
  logic [15:0] lnk_cmd_wdata;
  logic        lnk_sts_valid = 1'b0;
  logic        lnk_sts_ready = 1'b0;
  logic [15:0] lnk_sts_data = '0;
  logic        f_txe = 1'b0, f_txf = 1'b0, f_rxe = 1'b0, f_rxf = 1'b0;
  logic [3:0]  fev = '0;
  logic        acrst_n, sync_force, sync_gate, clk_en, blk_off;
  logic [9:0]  tx_slot_en, rx_slot_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ac97_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
    .lnk_cmd_valid(lnk_cmd_valid), .lnk_cmd_rd(lnk_cmd_rd),
    .lnk_cmd_idx(lnk_cmd_idx), .lnk_cmd_wdata(lnk_cmd_wdata),
    .lnk_sts_valid(lnk_sts_valid), .lnk_sts_ready(lnk_sts_ready),
    .lnk_sts_data(lnk_sts_data), .fifo_tx_empty(f_txe), .fifo_tx_full(f_txf),
    .fifo_rx_empty(f_rxe), .fifo_rx_full(f_rxf), .fifo_err_ev(fev),
    .acrst_n(acrst_n), .sync_force(sync_force), .sync_gate(sync_gate),
    .tx_slot_en(tx_slot_en), .rx_slot_en(rx_slot_en), .clk_en(clk_en),
    .blk_off(blk_off)
  );

  function automatic logic [31:0] cmd_word(input bit rdf, input logic [6:0] idx,
                                           input logic [15:0] d);
    return {d, 8'h00, rdf, idx};
  endfunction

  function automatic logic [31:0] exp_sts(input bit err, input logic [3:0] sev,
                                          input bit rdy, input bit pend);
    logic [31:0] s;
    s = '0;
    s[12] = err; s[11:8] = sev; s[7] = rdy; s[6] = pend;
    s[4] = f_txe; s[3] = f_txf; s[1] = f_rxe; s[0] = f_rxf;
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic sts_slot(input bit rdy, input logic [15:0] d);
    lnk_sts_valid = 1'b1; lnk_sts_ready = rdy; lnk_sts_data = d;
    @(negedge clk);
    lnk_sts_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [6:0]  ix;
    logic [15:0] dd;
    logic [3:0]  sev;
    v = $urandom(32'h0AC9_7001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_CFG, rv); chk("R1 cfg", rv, 32'h0);
    rd(A_ENA, rv); chk("R1 ena", rv, 32'h2);
    rd(A_STS, rv); chk("R1 sts", rv, 32'h0);
    rd(A_CMD, rv); chk("R1 cmd", rv, 32'h0000FFFF);
    chk("R1 acrst_n", {31'b0, acrst_n}, 32'h1);

    // R12 power-up sequence
    wr(A_ENA, 32'h3); wr(A_ENA, 32'h1);
    chk("R12 clk_en/blk_off", {30'b0, clk_en, blk_off}, 32'h2);

    // R10 random configuration
    for (int i = 0; i < 8; i++) begin
      v = $urandom() & 32'h007F_FFFF;
      wr(A_CFG, v);
      rd(A_CFG, rv); chk("R10 readback", rv, v);
      chk("R10 pins", {7'b0, rx_slot_en, tx_slot_en, sync_gate, sync_force, ~acrst_n},
          {7'b0, v[22:13], v[12:3], v[2], v[1], v[0]});
    end
    wr(A_CFG, (32'h3 << 13) | (32'h3 << 3));

    // R11 codec ready
    sts_slot(1'b1, 16'h0);
    rd(A_STS, rv); chk("R11 ready set", rv, exp_sts(0, 4'h0, 1, 0));
    wr(A_CFG, (32'h3 << 13) | (32'h3 << 3) | 32'h1);
    @(negedge clk);
    rd(A_STS, rv); chk("R11 ready cleared in cold reset", rv, exp_sts(0, 4'h0, 0, 0));
    chk("R10 acrst_n low", {31'b0, acrst_n}, 32'h0);
    sts_slot(1'b1, 16'h0);
    rd(A_STS, rv); chk("R11 ready held low", rv, exp_sts(0, 4'h0, 0, 0));
    wr(A_CFG, (32'h3 << 13) | (32'h3 << 3));
    sts_slot(1'b1, 16'h0);
    rd(A_STS, rv); chk("R11 ready again", rv, exp_sts(0, 4'h0, 1, 0));

    // R2 R3 R4 random write commands
    for (int i = 0; i < 6; i++) begin
      ix = 7'($urandom()); dd = 16'($urandom());
      wr(A_CMD, cmd_word(0, ix, dd));
      rd(A_STS, rv); chk("R2 pending set", rv, exp_sts(0, 4'h0, 1, 1));
      chk("R3 no pulse before tick", {31'b0, lnk_cmd_valid}, 32'h0);
      tick();
      chk("R3 issue", {8'b0, lnk_cmd_valid, lnk_cmd_rd, lnk_cmd_idx, lnk_cmd_wdata},
          {8'b0, 1'b1, 1'b0, ix, dd});
      @(negedge clk);
      chk("R3 single pulse", {31'b0, lnk_cmd_valid}, 32'h0);
      rd(A_STS, rv); chk("R4 still pending", rv, exp_sts(0, 4'h0, 1, 1));
      tick();
      rd(A_STS, rv); chk("R4 pending cleared", rv, exp_sts(0, 4'h0, 1, 0));
    end

    // R8 rejected command
    wr(A_CMD, cmd_word(0, 7'h2A, 16'h1234));
    wr(A_CMD, cmd_word(1, 7'h55, 16'hABCD));
    rd(A_STS, rv); chk("R8 error flagged", rv, exp_sts(1, 4'h0, 1, 1));
    tick();
    chk("R8 first command kept", {8'b0, lnk_cmd_valid, lnk_cmd_rd, lnk_cmd_idx, lnk_cmd_wdata},
        {8'b0, 1'b1, 1'b0, 7'h2A, 16'h1234});
    tick();
    rd(A_STS, rv); chk("R8 error sticky", rv, exp_sts(1, 4'h0, 1, 0));
    wr(A_STS, 32'h1000);
    rd(A_STS, rv); chk("R8 error cleared", rv, exp_sts(0, 4'h0, 1, 0));

    // R5 R6 read with response window
    wr(A_CMD, cmd_word(1, 7'h26, 16'h0));
    tick();
    chk("R3 read issue", {8'b0, lnk_cmd_valid, lnk_cmd_rd, lnk_cmd_idx},
        {8'b0, 1'b1, 1'b1, 7'h26});
    sts_slot(1'b1, 16'hBEEF);
    rd(A_STS, rv); chk("R5 pending cleared", rv, exp_sts(0, 4'h0, 1, 0));
    rd(A_CMD, rv); chk("R5 read data", rv, 32'h0000BEEF);
    tick();
    rd(A_CMD, rv); chk("R6 data within window", rv, 32'h0000BEEF);
    tick();
    rd(A_CMD, rv); chk("R6 window closed", rv, 32'h0000FFFF);

    // R7 read timeout
    wr(A_CMD, cmd_word(1, 7'h7C, 16'h0));
    tick();
    for (int i = 0; i < 3; i++) begin
      tick();
      rd(A_STS, rv); chk("R7 pending before timeout", rv, exp_sts(0, 4'h0, 1, 1));
    end
    tick();
    rd(A_STS, rv); chk("R7 timeout clears pending", rv, exp_sts(0, 4'h0, 1, 0));
    rd(A_CMD, rv); chk("R7 timeout data", rv, 32'h0000FFFF);

    // R12 link disabled ignores frame ticks
    wr(A_ENA, 32'h3);
    wr(A_CMD, cmd_word(0, 7'h11, 16'h5A5A));
    for (int i = 0; i < 2; i++) begin
      tick();
      chk("R12 no issue while disabled", {31'b0, lnk_cmd_valid}, 32'h0);
    end
    rd(A_STS, rv); chk("R12 pending held", rv, exp_sts(0, 4'h0, 1, 1));
    wr(A_ENA, 32'h0);
    tick();
    chk("R12 no issue with clock off", {31'b0, lnk_cmd_valid}, 32'h0);
    wr(A_ENA, 32'h1);
    tick();
    chk("R12 issue after enable", {8'b0, lnk_cmd_valid, lnk_cmd_rd, lnk_cmd_idx, lnk_cmd_wdata},
        {8'b0, 1'b1, 1'b0, 7'h11, 16'h5A5A});
    tick();

    // R9 live flags and sticky events
    f_txe = 1'b1; f_rxf = 1'b1;
    rd(A_STS, rv); chk("R9 live flags", rv, exp_sts(0, 4'h0, 1, 0));
    f_txe = 1'b0; f_txf = 1'b1; f_rxe = 1'b1; f_rxf = 1'b0;
    rd(A_STS, rv); chk("R9 live flags alt", rv, exp_sts(0, 4'h0, 1, 0));
    sev = 4'h0;
    for (int i = 0; i < 6; i++) begin
      v = $urandom();
      fev = v[3:0];
      @(negedge clk);
      fev = 4'h0;
      sev = sev | v[3:0];
      @(negedge clk);
      rd(A_STS, rv); chk("R9 sticky set", rv, exp_sts(0, sev, 1, 0));
      wr(A_STS, {20'b0, v[7:4], 8'b0});
      sev = sev & ~v[7:4];
      rd(A_STS, rv); chk("R9 w1c", rv, exp_sts(0, sev, 1, 0));
    end
    wr(A_STS, 32'h0F00);
    rd(A_STS, rv); chk("R9 all cleared", rv, exp_sts(0, 4'h0, 1, 0));

    finish_run();
  end

endmodule